// File: doc/BRIEF.md
# Received Bit Timing Error Classifier and Error-Bit Policy

This block sits behind the edge timer of a consumer-electronics control bus receiver. For every received bit the timer hands over two measured durations in microseconds: how long the line was held low, and the full period from one falling edge to the next. The block sorts the bit into three independent error classes:

- a misplaced rising edge;
- a period that is too short;
- a period that is too long.

A select input picks between a narrow and a wide acceptance window for the rising edge.

From the error classes and a set of policy enables, the block decides two things. First, whether reception of the current frame must stop. Second, whether the receiver should ask the line driver to send an error bit. The policy has layers. On frames sent to a single destination, the per-error enables apply. On broadcast frames, a separate broadcast option overrides those enables. A short period seen on a broadcast frame is also kept quiet while the receiver is in full listen mode. The error-bit waveform itself is produced elsewhere.

All results are registered. They appear for exactly one clock together with a result-valid flag, one cycle after the sample strobe.

Top module: `cec_rx_err_policy`

## Requirements
- R1: When `smp_valid` is high at a rising clock edge, `res_valid` and the five result outputs show that sample's results for exactly the following clock cycle. In every other cycle, and after reset, all six outputs are 0.
- R2: With `tol_wide`=0, `err_rise` is 1 when `low_us` lies outside both inclusive windows. The windows are 400..800 (a logic one, nominally 600) and 1300..1700 (a logic zero, nominally 1500).
- R3: With `tol_wide`=1, the windows widen to 250..950 and 1150..1850, both inclusive. `err_rise` is 1 outside both of them.
- R4: `err_short` is 1 when `period_us` is below 2050. A value of 2050 gives 0.
- R5: `err_long` is 1 when `period_us` is above 2750. A value of 2750 gives 0.
- R6: `rx_stop` is 1 exactly when `err_rise` is 1 and `stop_on_rise` is 1.
- R7: On a frame with `is_bcast`=0, a rising error requests an error bit only when both `ebit_on_rise` and `stop_on_rise` are 1.
- R8: On a frame with `is_bcast`=0, a long period requests an error bit exactly when `ebit_on_long` is 1.
- R9: On a frame with `is_bcast`=1 and `bcast_no_ebit`=0, two cases request an error bit regardless of `ebit_on_rise` and `ebit_on_long`. One is a rising error with `stop_on_rise`=1. The other is a long period.
- R10: On a frame with `is_bcast`=1 and `bcast_no_ebit`=1, neither a rising error nor a long period requests an error bit.
- R11: A short period requests an error bit, except on a frame with `is_bcast`=1 while `listen_full`=1.
- R12: `bcast_no_ebit` has no effect on `ebit_req` for frames with `is_bcast`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a measured bit is present |
| low_us | input | W (12) | Measured low time of the bit, in microseconds |
| period_us | input | W (12) | Measured full bit period, in microseconds |
| tol_wide | input | 1 | 0 selects the standard rising-edge window, 1 the extended one |
| stop_on_rise | input | 1 | A rising error stops reception |
| ebit_on_rise | input | 1 | Error-bit enable for rising errors |
| ebit_on_long | input | 1 | Error-bit enable for long-period errors |
| bcast_no_ebit | input | 1 | Suppresses error bits on broadcast frames |
| listen_full | input | 1 | Receiver is in full listen mode |
| is_bcast | input | 1 | Current frame is a broadcast |
| res_valid | output | 1 | Results below are valid this cycle |
| err_rise | output | 1 | Rising edge outside the accepted windows |
| err_short | output | 1 | Bit period too short |
| err_long | output | 1 | Bit period too long |
| rx_stop | output | 1 | Stop reception of the current frame |
| ebit_req | output | 1 | Request an error bit on the line |

## Verification
Every result of this block is due exactly one clock after the edge that captured `smp_valid`, because a single register stage lies between the inputs and all six outputs. The bench drives each sample on a falling edge and holds the strobe for one cycle. It then reads all six outputs on the next falling edge, which is half a period after the registering edge. One more falling edge later it confirms that everything has dropped back to 0. For this reason, no check depends on when the same-edge processes run relative to each other.

// File: rtl/cec_err_pkg.sv
// Package: shared types for the received-bit error classifier and policy.
// Assumes durations are delivered in microseconds by an external edge timer.
package cec_err_pkg;

    // The three timing error classes found on one received bit
    typedef struct packed {
        logic rise;
        logic shortp;
        logic longp;
    } timing_err_t;

    // Policy enables that decide stop and error-bit behaviour
    typedef struct packed {
        logic stop_on_rise;
        logic ebit_on_rise;
        logic ebit_on_long;
        logic bcast_no_ebit;
        logic listen_full;
        logic is_bcast;
    } ebit_cfg_t;

    // Policy decision for one bit
    typedef struct packed {
        logic stop;
        logic ebit;
    } policy_out_t;

endpackage

// File: rtl/cec_bit_classifier.sv
// Module: cec_bit_classifier
// Combinationally sorts a measured bit into rising-edge, short-period and
// long-period errors. The rising edge is accepted when the low time falls
// inside an inclusive window around either nominal low time. Assumes every
// window bound fits in W bits and that the lower bounds are not negative.
module cec_bit_classifier
    import cec_err_pkg::*;
#(
    parameter int W        = 12,
    parameter int ONE_LOW  = 600,
    parameter int ZERO_LOW = 1500,
    parameter int TOL_STD  = 200,
    parameter int TOL_EXT  = 350,
    parameter int PER_MIN  = 2050,
    parameter int PER_MAX  = 2750
) (
    input  logic [W-1:0] low_us,
    input  logic [W-1:0] period_us,
    input  logic         tol_wide,
    output timing_err_t  err
);
    localparam int NNOM = 2;
    localparam int NOM [NNOM] = '{ONE_LOW, ZERO_LOW};
    localparam logic [W-1:0] PMIN = W'(PER_MIN);
    localparam logic [W-1:0] PMAX = W'(PER_MAX);

    logic [NNOM-1:0] in_win;

    // One acceptance window per nominal low time; the tolerance picks bounds
    for (genvar g = 0; g < NNOM; g++) begin : g_win
        localparam logic [W-1:0] LO_STD = W'(NOM[g] - TOL_STD);
        localparam logic [W-1:0] HI_STD = W'(NOM[g] + TOL_STD);
        localparam logic [W-1:0] LO_EXT = W'(NOM[g] - TOL_EXT);
        localparam logic [W-1:0] HI_EXT = W'(NOM[g] + TOL_EXT);
        logic [W-1:0] lo, hi;
        // Select the window bounds for the active tolerance
        always_comb begin
            lo = tol_wide ? LO_EXT : LO_STD;
            hi = tol_wide ? HI_EXT : HI_STD;
            in_win[g] = (low_us >= lo) && (low_us <= hi);
        end
    end

    // Combine the window hits and the period limits into error flags
    always_comb begin
        err.rise   = ~|in_win;
        err.shortp = period_us < PMIN;
        err.longp  = period_us > PMAX;
    end

endmodule

// File: rtl/cec_errbit_policy.sv
// Module: cec_errbit_policy
// Combinationally decides whether to stop reception and whether to request an
// error bit. Frames sent to one destination obey the per-error enables. On
// broadcast frames a separate option overrides them, and a short period stays
// quiet in full listen mode. Assumes the error flags belong to the frame
// described by cfg.
module cec_errbit_policy
    import cec_err_pkg::*;
(
    input  timing_err_t err,
    input  ebit_cfg_t   cfg,
    output policy_out_t dec
);
    logic from_rise, from_long, from_short;

    // Evaluate each error-bit source under the layered policy
    always_comb begin
        from_rise  = err.rise & cfg.stop_on_rise &
                     (cfg.is_bcast ? ~cfg.bcast_no_ebit : cfg.ebit_on_rise);
        from_long  = err.longp &
                     (cfg.is_bcast ? ~cfg.bcast_no_ebit : cfg.ebit_on_long);
        from_short = err.shortp & ~(cfg.is_bcast & cfg.listen_full);
        dec.stop   = err.rise & cfg.stop_on_rise;
        dec.ebit   = from_rise | from_long | from_short;
    end

endmodule

// File: rtl/cec_rx_err_policy.sv
// Module: cec_rx_err_policy (top)
// Classifies each measured received bit and applies the stop and error-bit
// policy. Every result is registered once and shown for one cycle with
// res_valid. Assumes smp_valid is a single-cycle strobe and the policy
// inputs are steady while it is high.
module cec_rx_err_policy
    import cec_err_pkg::*;
#(
    parameter int W        = 12,
    parameter int ONE_LOW  = 600,
    parameter int ZERO_LOW = 1500,
    parameter int TOL_STD  = 200,
    parameter int TOL_EXT  = 350,
    parameter int PER_MIN  = 2050,
    parameter int PER_MAX  = 2750
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] low_us,
    input  logic [W-1:0] period_us,
    input  logic         tol_wide,
    input  logic         stop_on_rise,
    input  logic         ebit_on_rise,
    input  logic         ebit_on_long,
    input  logic         bcast_no_ebit,
    input  logic         listen_full,
    input  logic         is_bcast,
    output logic         res_valid,
    output logic         err_rise,
    output logic         err_short,
    output logic         err_long,
    output logic         rx_stop,
    output logic         ebit_req
);
    timing_err_t terr;
    ebit_cfg_t   cfg;
    policy_out_t dec;

    // Gather the policy inputs into one struct
    always_comb begin
        cfg.stop_on_rise  = stop_on_rise;
        cfg.ebit_on_rise  = ebit_on_rise;
        cfg.ebit_on_long  = ebit_on_long;
        cfg.bcast_no_ebit = bcast_no_ebit;
        cfg.listen_full   = listen_full;
        cfg.is_bcast      = is_bcast;
    end

    cec_bit_classifier #(
        .W(W), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
        .TOL_STD(TOL_STD), .TOL_EXT(TOL_EXT),
        .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
    ) u_class (
        .low_us   (low_us),
        .period_us(period_us),
        .tol_wide (tol_wide),
        .err      (terr)
    );

    cec_errbit_policy u_pol (
        .err(terr),
        .cfg(cfg),
        .dec(dec)
    );

    // Register the results for one cycle; clear everything when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            err_rise  <= 1'b0;
            err_short <= 1'b0;
            err_long  <= 1'b0;
            rx_stop   <= 1'b0;
            ebit_req  <= 1'b0;
        end else begin
            res_valid <= smp_valid;
            err_rise  <= smp_valid & terr.rise;
            err_short <= smp_valid & terr.shortp;
            err_long  <= smp_valid & terr.longp;
            rx_stop   <= smp_valid & dec.stop;
            ebit_req  <= smp_valid & dec.ebit;
        end
    end

endmodule

// File: rtl/cec_rx_err_policy_chk.sv
// Module: cec_rx_err_policy_chk
// Checker relating the top-level inputs to the registered outputs one cycle
// later. Attached to every instance of the top module by the bind below.
module cec_rx_err_policy_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic stop_on_rise,
    input logic bcast_no_ebit,
    input logic listen_full,
    input logic is_bcast,
    input logic res_valid,
    input logic err_rise,
    input logic err_short,
    input logic err_long,
    input logic rx_stop,
    input logic ebit_req
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> res_valid);  // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !res_valid);  // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(err_rise || err_short || err_long || rx_stop || ebit_req));  // R1
    AST_STOP_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop |-> err_rise);  // R6
    AST_STOP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (rx_stop == (err_rise && $past(stop_on_rise))));  // R6
    AST_BCAST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && is_bcast && bcast_no_ebit) |=>
        (!ebit_req || (err_short && !$past(listen_full))));  // R10
    AST_SHORT_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && is_bcast && listen_full && bcast_no_ebit) |=> !ebit_req);  // R11
endmodule

bind cec_rx_err_policy cec_rx_err_policy_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .stop_on_rise (stop_on_rise),
    .bcast_no_ebit(bcast_no_ebit),
    .listen_full  (listen_full),
    .is_bcast     (is_bcast),
    .res_valid    (res_valid),
    .err_rise     (err_rise),
    .err_short    (err_short),
    .err_long     (err_long),
    .rx_stop      (rx_stop),
    .ebit_req     (ebit_req)
);

// File: tb/cec_rx_err_policy_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module cec_rx_err_policy_tb;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [W-1:0] low_us = '0;
    logic [W-1:0] period_us = '0;
    logic tol_wide = 1'b0;
    logic stop_on_rise = 1'b0, ebit_on_rise = 1'b0, ebit_on_long = 1'b0;
    logic bcast_no_ebit = 1'b0, listen_full = 1'b0, is_bcast = 1'b0;
    logic res_valid, err_rise, err_short, err_long, rx_stop, ebit_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cec_rx_err_policy u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .low_us(low_us), .period_us(period_us), .tol_wide(tol_wide),
        .stop_on_rise(stop_on_rise), .ebit_on_rise(ebit_on_rise),
        .ebit_on_long(ebit_on_long), .bcast_no_ebit(bcast_no_ebit),
        .listen_full(listen_full), .is_bcast(is_bcast),
        .res_valid(res_valid), .err_rise(err_rise), .err_short(err_short),
        .err_long(err_long), .rx_stop(rx_stop), .ebit_req(ebit_req)
    );

    // Compare the packed outputs {valid,rise,short,long,stop,ebit}
    task automatic chk(input string tag, input logic [5:0] exp);
        logic [5:0] got;
        got = {res_valid, err_rise, err_short, err_long, rx_stop, ebit_req};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Set the policy inputs
    task automatic cfg(input logic sr, input logic er, input logic el,
                       input logic nb, input logic lf, input logic bc);
        stop_on_rise = sr; ebit_on_rise = er; ebit_on_long = el;
        bcast_no_ebit = nb; listen_full = lf; is_bcast = bc;
    endtask

    // Present one sample, check the result one cycle later and idle after
    task automatic probe(input string tag, input int lo, input int per,
                         input logic [4:0] exp);
        @(negedge clk);
        low_us = W'(lo); period_us = W'(per); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(tag, {1'b1, exp});
        @(negedge clk);
        chk({tag, " R1 idle"}, 6'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset", 6'b0);
    endtask

    task automatic t_std_window();
        tol_wide = 1'b0; cfg(0, 0, 0, 0, 0, 0);
        probe("R2 600", 600, 2400, 5'b00000);
        probe("R2 399", 399, 2400, 5'b10000);
        probe("R2 400", 400, 2400, 5'b00000);
        probe("R2 800", 800, 2400, 5'b00000);
        probe("R2 801", 801, 2400, 5'b10000);
        probe("R2 1299", 1299, 2400, 5'b10000);
        probe("R2 1300", 1300, 2400, 5'b00000);
        probe("R2 1700", 1700, 2400, 5'b00000);
        probe("R2 1701", 1701, 2400, 5'b10000);
    endtask

    task automatic t_ext_window();
        tol_wide = 1'b1; cfg(0, 0, 0, 0, 0, 0);
        probe("R3 249", 249, 2400, 5'b10000);
        probe("R3 250", 250, 2400, 5'b00000);
        probe("R3 950", 950, 2400, 5'b00000);
        probe("R3 951", 951, 2400, 5'b10000);
        probe("R3 1149", 1149, 2400, 5'b10000);
        probe("R3 1150", 1150, 2400, 5'b00000);
        probe("R3 1850", 1850, 2400, 5'b00000);
        probe("R3 1851", 1851, 2400, 5'b10000);
        tol_wide = 1'b0;
    endtask

    task automatic t_period();
        cfg(0, 0, 0, 0, 0, 0);
        probe("R4 2049", 600, 2049, 5'b01001);
        probe("R4 2050", 600, 2050, 5'b00000);
        probe("R5 2750", 600, 2750, 5'b00000);
        probe("R5 2751", 600, 2751, 5'b00100);
    endtask

    task automatic t_stop();
        cfg(1, 0, 0, 0, 0, 0);
        probe("R6 stop", 1000, 2400, 5'b10010);
        cfg(0, 1, 0, 0, 0, 0);
        probe("R6 nostop", 1000, 2400, 5'b10000);
    endtask

    task automatic t_unicast();
        cfg(1, 1, 0, 0, 0, 0);
        probe("R7 both", 1000, 2400, 5'b10011);
        cfg(0, 1, 0, 0, 0, 0);
        probe("R7 gen only", 1000, 2400, 5'b10000);
        cfg(1, 0, 0, 0, 0, 0);
        probe("R7 stop only", 1000, 2400, 5'b10010);
        cfg(0, 0, 1, 0, 0, 0);
        probe("R8 long en", 600, 3000, 5'b00101);
        cfg(0, 0, 0, 0, 0, 0);
        probe("R8 long dis", 600, 3000, 5'b00100);
        cfg(1, 1, 1, 1, 0, 0);
        probe("R12 rise", 1000, 2400, 5'b10011);
        probe("R12 long", 600, 3000, 5'b00101);
    endtask

    task automatic t_bcast_gen();
        cfg(1, 0, 0, 0, 0, 1);
        probe("R9 rise", 1000, 2400, 5'b10011);
        cfg(0, 0, 0, 0, 0, 1);
        probe("R9 rise nostop", 1000, 2400, 5'b10000);
        probe("R9 long", 600, 3000, 5'b00101);
    endtask

    task automatic t_bcast_nogen();
        cfg(1, 1, 1, 1, 0, 1);
        probe("R10 rise", 1000, 2400, 5'b10010);
        probe("R10 long", 600, 3000, 5'b00100);
    endtask

    task automatic t_short();
        cfg(0, 0, 0, 0, 1, 1);
        probe("R11 bc full", 600, 1800, 5'b01000);
        cfg(0, 0, 0, 0, 0, 1);
        probe("R11 bc reduced", 600, 1800, 5'b01001);
        cfg(0, 0, 0, 0, 1, 0);
        probe("R11 uni full", 600, 1800, 5'b01001);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_std_window();
        t_ext_window();
        t_period();
        t_stop();
        t_unicast();
        t_bcast_gen();
        t_bcast_nogen();
        t_short();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule